// File: doc/BRIEF.md
# Domain Protection Root CSR

This block is the machine-level root register of a page-based physical memory protection table. It holds three fields: a table mode, a supervisor-domain identifier and the page number of the root table. It decodes CSR accesses aimed at its address, and it applies write-any-read-legal rules to every write. It raises a trap for illegal accesses. It presents the current mode, domain identifier and root page number to a table walker. It also presents an enable that says whether checks apply at the current privilege level.

The XLEN parameter selects a 32-bit or a 64-bit layout, and with it the set of legal modes. The SDID_LEN parameter sets how many low domain-identifier bits are implemented. Software finds that count by writing all ones to the identifier field and reading back which bits stayed set. The walk through the table is done elsewhere.

Top module: `dpt_root_csr`

## Requirements
- R1: After reset the mode is Bare (0), the domain identifier and root page number are zero, a read returns 0 and the protection enable is low.
- R2: Field layout. For XLEN=64: mode in bits 63:60, identifier in bits 59:44, page number in bits 43:0. For XLEN=32: mode in bit 31, identifier in bits 30:22, page number in bits 21:0. A machine-mode read returns the register in this layout.
- R3: Legal modes for XLEN=64 are 0 (Bare), 1 (46-bit table) and 2 (56-bit table). For XLEN=32 they are 0 (Bare) and 1 (34-bit table); value 2 is reserved there and cannot be encoded. A write whose resulting mode is reserved (3 to 15 for XLEN=64) leaves the whole register unchanged and raises no trap.
- R4: A write whose resulting mode is Bare, and whose identifier or page-number field is nonzero (the raw field, before any bits are dropped), raises the trap and leaves the register unchanged. A Bare write with both fields zero clears the register.
- R5: In a table mode, bits 1:0 of the stored root page number are always zero, whatever was written.
- R6: Only identifier bits [SDID_LEN-1:0] are kept, with SDID_LEN at most 6. All higher identifier bits read as zero.
- R7: An access at the CSR address with privilege other than machine (priv_i != 2'b11) raises the trap, returns 0 and changes nothing. An access to any other address raises no trap and changes nothing.
- R8: Operation codes on csr_op_i are 0 read, 1 write, 2 set bits and 3 clear bits. Set and clear combine the write data with the current value. The combined value is then legalised exactly as a write would be.
- R9: The walker outputs show the stored fields. prot_active_o is high only when the privilege is not machine and the mode is not Bare.
- R10: A write takes effect at the next clock edge. A read returns the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_valid_i | input | 1 | CSR access this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | XLEN | Write or mask data |
| priv_i | input | 2 | Effective privilege, 3 = machine |
| csr_rdata_o | output | XLEN | Read data, 0 unless a granted access |
| csr_trap_o | output | 1 | Illegal access or Bare-mode fault |
| mode_o | output | 4 | Current mode, zero-extended |
| sdid_o | output | 6 | Current domain identifier |
| root_ppn_o | output | 22 or 44 | Root table page number |
| prot_active_o | output | 1 | Protection checks apply |

## Verification
The bench builds the block with XLEN=64 and SDID_LEN=4. With these values, writing all ones to the identifier field shows both the kept bits and the dropped bits. The full range of reserved mode codes can also be reached, including values well above the legal ones. The 64-bit layout also lets the bench write set and clear masks that turn a table mode back into Bare while page-number bits remain. This exercises the Bare fault through the combine path as well as through plain writes.

// File: rtl/dpt_pkg.sv
`timescale 1ns/1ps
package dpt_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [1:0] PRIV_M   = 2'b11;
  localparam int         SDID_MAX = 6;
endpackage

// File: rtl/dpt_access_dec.sv
`timescale 1ns/1ps
module dpt_access_dec
  import dpt_pkg::*;
#(
  parameter logic [11:0] CSR_ADDR = 12'h5A8
) (
  input  logic        valid_i,
  input  logic [11:0] addr_i,
  input  csr_op_e     op_i,
  input  logic [1:0]  priv_i,
  output logic        grant_o,
  output logic        deny_o,
  output logic        wr_req_o
);
  logic hit;
  assign hit      = valid_i && (addr_i == CSR_ADDR);
  assign grant_o  = hit && (priv_i == PRIV_M);
  assign deny_o   = hit && (priv_i != PRIV_M);
  assign wr_req_o = grant_o && (op_i != OP_READ);
endmodule

// File: rtl/dpt_legalize.sv
`timescale 1ns/1ps
module dpt_legalize
  import dpt_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int SDID_LEN = 6,
  localparam int MODE_W  = (XLEN == 32) ? 1 : 4,
  localparam int SDID_W  = (XLEN == 32) ? 9 : 16,
  localparam int PPN_W   = (XLEN == 32) ? 22 : 44
) (
  input  logic [XLEN-1:0]     cur_i,
  input  csr_op_e             op_i,
  input  logic [XLEN-1:0]     wdata_i,
  output logic                mode_ok_o,
  output logic                bare_fault_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic [SDID_MAX-1:0] sdid_o,
  output logic [PPN_W-1:0]    ppn_o
);
  localparam logic [SDID_MAX-1:0] SDID_MASK =
    SDID_MAX'((7'd1 << SDID_LEN) - 7'd1);

  logic [XLEN-1:0]   nxt;
  logic [MODE_W-1:0] mode_raw;
  logic [SDID_W-1:0] sdid_raw;
  logic [PPN_W-1:0]  ppn_raw;
  logic              is_bare;

  always_comb begin
    case (op_i)
      OP_SET:   nxt = cur_i | wdata_i;
      OP_CLEAR: nxt = cur_i & ~wdata_i;
      default:  nxt = wdata_i;
    endcase
  end

  assign mode_raw = nxt[XLEN-1 -: MODE_W];
  assign sdid_raw = nxt[PPN_W +: SDID_W];
  assign ppn_raw  = nxt[PPN_W-1:0];
  assign is_bare  = (mode_raw == '0);

  generate
    if (XLEN == 32) begin : g_mode32
      assign mode_ok_o = 1'b1;  // 1-bit field: both codes legal
    end else begin : g_mode64
      assign mode_ok_o = (mode_raw <= MODE_W'(2));
    end
  endgenerate

  assign bare_fault_o = is_bare && ((sdid_raw != '0) || (ppn_raw != '0));
  assign mode_o       = mode_raw;
  assign sdid_o       = is_bare ? '0 : (sdid_raw[SDID_MAX-1:0] & SDID_MASK);
  assign ppn_o        = is_bare ? '0 : {ppn_raw[PPN_W-1:2], 2'b00};
endmodule

// File: rtl/dpt_root_reg.sv
`timescale 1ns/1ps
module dpt_root_reg
  import dpt_pkg::*;
#(
  parameter int MODE_W = 4,
  parameter int PPN_W  = 44
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [SDID_MAX-1:0] sdid_i,
  input  logic [PPN_W-1:0]    ppn_i,
  output logic [MODE_W-1:0]   mode_q_o,
  output logic [SDID_MAX-1:0] sdid_q_o,
  output logic [PPN_W-1:0]    ppn_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= '0;
      sdid_q_o <= '0;
      ppn_q_o  <= '0;
    end else if (we_i) begin
      mode_q_o <= mode_i;
      sdid_q_o <= sdid_i;
      ppn_q_o  <= ppn_i;
    end
  end
endmodule

// File: rtl/dpt_root_csr.sv
`timescale 1ns/1ps
module dpt_root_csr
  import dpt_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          SDID_LEN = 6,
  parameter logic [11:0] CSR_ADDR = 12'h5A8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             csr_valid_i,
  input  logic [11:0]                      csr_addr_i,
  input  logic [1:0]                       csr_op_i,
  input  logic [XLEN-1:0]                  csr_wdata_i,
  input  logic [1:0]                       priv_i,
  output logic [XLEN-1:0]                  csr_rdata_o,
  output logic                             csr_trap_o,
  output logic [3:0]                       mode_o,
  output logic [5:0]                       sdid_o,
  output logic [((XLEN == 32) ? 22 : 44)-1:0] root_ppn_o,
  output logic                             prot_active_o
);
  localparam int MODE_W = (XLEN == 32) ? 1 : 4;
  localparam int SDID_W = (XLEN == 32) ? 9 : 16;
  localparam int PPN_W  = (XLEN == 32) ? 22 : 44;

  csr_op_e             op;
  logic                grant, deny, wr_req;
  logic                mode_ok, bare_fault, we;
  logic [MODE_W-1:0]   new_mode, mode_q;
  logic [SDID_MAX-1:0] new_sdid, sdid_q;
  logic [PPN_W-1:0]    new_ppn, ppn_q;
  logic [XLEN-1:0]     cur_word;

  assign op = csr_op_e'(csr_op_i);

  dpt_access_dec #(.CSR_ADDR(CSR_ADDR)) u_dec (
    .valid_i  (csr_valid_i),
    .addr_i   (csr_addr_i),
    .op_i     (op),
    .priv_i   (priv_i),
    .grant_o  (grant),
    .deny_o   (deny),
    .wr_req_o (wr_req)
  );

  dpt_legalize #(.XLEN(XLEN), .SDID_LEN(SDID_LEN)) u_legal (
    .cur_i        (cur_word),
    .op_i         (op),
    .wdata_i      (csr_wdata_i),
    .mode_ok_o    (mode_ok),
    .bare_fault_o (bare_fault),
    .mode_o       (new_mode),
    .sdid_o       (new_sdid),
    .ppn_o        (new_ppn)
  );

  // reserved mode: silently keep old value; Bare with payload: trap
  assign we = wr_req && mode_ok && !bare_fault;

  dpt_root_reg #(.MODE_W(MODE_W), .PPN_W(PPN_W)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .mode_i   (new_mode),
    .sdid_i   (new_sdid),
    .ppn_i    (new_ppn),
    .mode_q_o (mode_q),
    .sdid_q_o (sdid_q),
    .ppn_q_o  (ppn_q)
  );

  assign cur_word = {mode_q, {(SDID_W-SDID_MAX){1'b0}}, sdid_q, ppn_q};

  assign csr_rdata_o   = grant ? cur_word : '0;
  assign csr_trap_o    = deny || (wr_req && mode_ok && bare_fault);
  assign mode_o        = 4'(mode_q);
  assign sdid_o        = sdid_q;
  assign root_ppn_o    = ppn_q;
  assign prot_active_o = (priv_i != PRIV_M) && (mode_q != '0);
endmodule

// File: rtl/dpt_root_csr_chk.sv
`timescale 1ns/1ps
module dpt_root_csr_chk #(
  parameter int          XLEN     = 64,
  parameter int          SDID_LEN = 6,
  parameter logic [11:0] CSR_ADDR = 12'h5A8,
  localparam int         PPN_W    = (XLEN == 32) ? 22 : 44
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csr_valid_i,
  input logic [11:0]      csr_addr_i,
  input logic [1:0]       priv_i,
  input logic             csr_trap_o,
  input logic [3:0]       mode_o,
  input logic [5:0]       sdid_o,
  input logic [PPN_W-1:0] root_ppn_o,
  input logic             prot_active_o
);
  localparam logic [3:0] MODE_MAX = (XLEN == 32) ? 4'd1 : 4'd2;

  p_mode_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= MODE_MAX);

  p_bare_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd0) |-> (sdid_o == 6'd0 && root_ppn_o == '0));

  p_trap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_trap_o |=> ($stable(mode_o) && $stable(sdid_o) && $stable(root_ppn_o)));

  p_ppn_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 4'd0) |-> (root_ppn_o[1:0] == 2'b00));

  p_sdid_trunc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sdid_o >> SDID_LEN) == 6'd0));

  p_priv_trap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_addr_i == CSR_ADDR && priv_i != 2'b11) |-> csr_trap_o);

  p_m_inactive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == 2'b11) |-> !prot_active_o);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_valid_i |=> ($stable(mode_o) && $stable(sdid_o) && $stable(root_ppn_o)));
endmodule

bind dpt_root_csr dpt_root_csr_chk #(
  .XLEN(XLEN), .SDID_LEN(SDID_LEN), .CSR_ADDR(CSR_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_valid_i   (csr_valid_i),
  .csr_addr_i    (csr_addr_i),
  .priv_i        (priv_i),
  .csr_trap_o    (csr_trap_o),
  .mode_o        (mode_o),
  .sdid_o        (sdid_o),
  .root_ppn_o    (root_ppn_o),
  .prot_active_o (prot_active_o)
);

// File: tb/dpt_root_csr_bench.sv
`timescale 1ns/1ps
module dpt_root_csr_bench;
  localparam int          XLEN = 64;
  localparam int          SLEN = 4;
  localparam logic [11:0] ADDR = 12'h5A8;

  typedef struct {
    string       tag;
    bit          trap;
    bit          chk_rd;
    logic [63:0] rd;
    logic [3:0]  mode;
    logic [5:0]  sdid;
    logic [43:0] ppn;
    bit          active;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_valid = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic [63:0] csr_wdata = '0;
  logic [1:0]  priv = 2'b11;
  logic [63:0] csr_rdata;
  logic        csr_trap;
  logic [3:0]  mode;
  logic [5:0]  sdid;
  logic [43:0] root_ppn;
  logic        prot_active;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  item_t exp_q[$];

  logic [3:0]  m_mode = '0;
  logic [15:0] m_sdid = '0;
  logic [43:0] m_ppn = '0;

  always #2.5 clk = ~clk;

  dpt_root_csr #(.XLEN(XLEN), .SDID_LEN(SLEN), .CSR_ADDR(ADDR)) u_dpt_root_csr (
    .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(csr_valid), .csr_addr_i(csr_addr),
    .csr_op_i(csr_op), .csr_wdata_i(csr_wdata), .priv_i(priv),
    .csr_rdata_o(csr_rdata), .csr_trap_o(csr_trap), .mode_o(mode), .sdid_o(sdid),
    .root_ppn_o(root_ppn), .prot_active_o(prot_active)
  );

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] word(logic [3:0] md, logic [15:0] sd, logic [43:0] pp);
    return {md, sd, pp};
  endfunction

  task automatic acc(logic [1:0] op, logic [11:0] addr, logic [1:0] pv,
                     logic [63:0] wd, string tag);
    item_t it;
    logic [63:0] old, nw;
    @(negedge clk);
    csr_valid = 1'b1; csr_op = op; csr_addr = addr; csr_wdata = wd; priv = pv;
    old = word(m_mode, m_sdid, m_ppn);
    it.tag = tag; it.trap = 0; it.chk_rd = (op == 2'd0) || (pv != 2'b11);
    it.rd = 64'd0;
    if (addr == ADDR) begin
      if (pv != 2'b11) it.trap = 1;
      else begin
        it.rd = old;
        if (op != 2'd0) begin
          nw = (op == 2'd2) ? (old | wd) : (op == 2'd3) ? (old & ~wd) : wd;
          if (nw[63:60] > 4'd2) begin
            // reserved: no change
          end else if (nw[63:60] == 4'd0) begin
            if (nw[59:0] != 60'd0) it.trap = 1;
            else begin m_mode = 0; m_sdid = 0; m_ppn = 0; end
          end else begin
            m_mode = nw[63:60];
            m_sdid = nw[59:44] & 16'h000F;
            m_ppn  = {nw[43:2], 2'b00};
          end
        end
      end
    end
    it.mode = m_mode; it.sdid = m_sdid[5:0]; it.ppn = m_ppn;
    it.active = (pv != 2'b11) && (m_mode != 0);
    exp_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    csr_valid = 1'b0;
  endtask

  // monitor: trap/read data mid-cycle, state just after the edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (csr_valid && exp_q.size() > 0) begin
        it = exp_q.pop_front();
        chk(csr_trap == it.trap, it.tag, "trap", 64'(csr_trap), 64'(it.trap));
        if (it.chk_rd) chk(csr_rdata == it.rd, it.tag, "rdata", csr_rdata, it.rd);
        @(posedge clk);
        #1;
        chk(mode == it.mode, it.tag, "mode", 64'(mode), 64'(it.mode));
        chk(sdid == it.sdid, it.tag, "sdid", 64'(sdid), 64'(it.sdid));
        chk(root_ppn == it.ppn, it.tag, "ppn", 64'(root_ppn), 64'(it.ppn));
        chk(prot_active == it.active, it.tag, "active", 64'(prot_active), 64'(it.active));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(mode == 0 && sdid == 0 && root_ppn == 0, "R1", "reset fields",
        {mode, 10'd0, sdid, root_ppn}, 64'd0);
    chk(prot_active == 0, "R1", "reset active", 64'(prot_active), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    acc(2'd0, ADDR, 2'b11, 64'd0, "R1 reset read");
    // R5/R6/R2: all-ones identifier, unaligned page number
    acc(2'd1, ADDR, 2'b11, {4'd1, 16'hFFFF, 44'hABC_DEF1_2347}, "R6 R5 write");
    acc(2'd0, ADDR, 2'b11, 64'd0, "R2 R10 read");
    // R7 non-machine accesses
    acc(2'd0, ADDR, 2'b01, 64'd0, "R7 S read R9");
    acc(2'd1, ADDR, 2'b00, {4'd2, 16'h1, 44'h400}, "R7 U write");
    acc(2'd1, ADDR + 12'd1, 2'b11, {4'd2, 16'h1, 44'h400}, "R7 other addr");
    acc(2'd0, ADDR, 2'b11, 64'd0, "R9 M inactive");
    // R3 reserved modes
    acc(2'd1, ADDR, 2'b11, {4'd3, 16'h2, 44'h800}, "R3 mode3");
    acc(2'd1, ADDR, 2'b11, {4'd15, 16'h0, 44'h0}, "R3 mode15");
    acc(2'd1, ADDR, 2'b11, {4'd2, 16'h5, 44'h100}, "R3 mode2");
    // R8 set and clear
    acc(2'd2, ADDR, 2'b11, {4'd0, 16'h2, 44'h3}, "R8 set");
    acc(2'd3, ADDR, 2'b11, {4'd0, 16'h1, 44'h0}, "R8 clear");
    acc(2'd0, ADDR, 2'b11, 64'd0, "R8 readback");
    acc(2'd3, ADDR, 2'b11, {4'hF, 16'h0, 44'h0}, "R8 R4 clear to bare");
    acc(2'd2, ADDR, 2'b11, {4'hC, 16'h0, 44'h0}, "R8 R3 set reserved");
    // R4 Bare faults and clean clear
    acc(2'd1, ADDR, 2'b11, {4'd0, 16'h0, 44'h1}, "R4 bare ppn");
    acc(2'd1, ADDR, 2'b11, {4'd0, 16'h0400, 44'h0}, "R4 bare high sdid");
    acc(2'd1, ADDR, 2'b11, 64'd0, "R4 bare clean");
    acc(2'd0, ADDR, 2'b01, 64'd0, "R9 S bare inactive");
    acc(2'd1, ADDR, 2'b11, {4'd1, 16'h0, 44'h7}, "R5 low bits");
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule